// File: doc/BRIEF.md
# Daisy-Chain Ring Bus Node

This block is one station on a 16-bit ring bus. Every word entering the node leaves it one clock later, so a chain of nodes behaves like a shift register. The node watches the passing stream for a framing pair (a zero word and then the marker 0xEB90). It decodes the command word and the start address that follow. It then acts on the words of the message that fall inside its own address window.

On a write, the node presents the matching data words on a local register-file port and forwards the message unchanged. On a read, the generator sends zero filler words, and the node overwrites each filler word that lands in its window with its answer. A node finds its base address from its position in the chain. An address-assignment message carries the next free address. Each node keeps that value as its base and forwards the address that follows its own window.

Top module: `ring_node`

## Requirements
- R1: Every input word appears on `out_data` exactly one clock later, and `out_valid` is `in_valid` delayed by one clock. After reset `out_valid` and `reg_wr_en` are 0. Cycles with `in_valid` low leave the parse state unchanged.
- R2: A frame begins when a valid word 0xEB90 directly follows a valid word 0x0000. The next valid word is decoded as a command. This pair restarts parsing from any state, even in the middle of a message, and the 0xEB90 word is forwarded unchanged.
- R3: In a command word, bits [15:10] must be zero. Bit 9 selects write (1) or read (0), and bits [8:0] give the length L. Command 0xFE00 is address assignment. Any other value abandons the frame.
- R4: A read or write command with L = 0 is ignored: the node returns to searching, and the words that follow pass through unchanged.
- R5: On address assignment, the node stores the word after 0xFE00 as its base. In place of that word it forwards base + NODE_LEN.
- R6: A data word whose address lies outside [base, base+NODE_LEN-1] is forwarded unchanged and causes no register write.
- R7: On a read, a word at window offset 0 is replaced by NODE_ID, offset 1 by NODE_LEN, and offset k ≥ 2 by `reg_rd_data` while `reg_rd_idx` = k-2.
- R8: On a write, a word at offset k ≥ 2 gives a one-cycle `reg_wr_en` pulse with `reg_wr_idx` = k-2, and `reg_wr_data` holds that word, all in the same cycle as it appears on `out_data`. Writes to offsets 0 and 1 are ignored.
- R9: Until the first address assignment, the node neither replaces read words nor issues writes.
- R10: The window test is made for each word, so a message that crosses the window edge is handled only for the words inside it.
- R11: After the L-th data word the node returns to searching, and later words pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 16 | Upstream word |
| out_valid | output | 1 | Downstream word valid |
| out_data | output | 16 | Downstream word (forwarded or substituted) |
| reg_wr_en | output | 1 | Local register write strobe |
| reg_wr_idx | output | IW | Local register index for the write |
| reg_wr_data | output | 16 | Local register write data |
| reg_rd_idx | output | IW | Local register index for the read (combinational) |
| reg_rd_data | input | 16 | Local register read data, returned in the same cycle |

## Verification
Every result of this node is due one clock after the word that causes it. This covers the forwarded or substituted word, the incremented address on assignment, and the write strobe with its index and data. The bench drives each word on a falling edge and checks the outputs just after the next rising edge. The register model answers reads within the same cycle and takes writes on the edge after the strobe. Read-back messages are therefore placed well after the writes they depend on. Gaps in `in_valid` are checked for a low `out_valid` in the following cycle, with parsing resumed afterwards.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam logic [15:0] FRAME_ZERO = 16'h0000;
    localparam logic [15:0] FRAME_MARK = 16'hEB90;
    localparam logic [15:0] CMD_ASSIGN = 16'hFE00;

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_CMD,
        ST_ADDR,
        ST_DATA
    } ring_st_e;

    typedef struct packed {
        ring_st_e    st;
        logic        last_zero;
        logic        assign_op;
        logic        write_op;
        logic [15:0] base;
        logic        base_ok;
        logic [15:0] addr;
        logic [8:0]  remain;
        logic        out_valid;
        logic [15:0] out_data;
        logic        wr_en;
        logic [15:0] wr_off;
        logic [15:0] wr_data;
    } ring_state_t;

endpackage

// File: rtl/ring_window.sv
module ring_window #(
    parameter int NODE_LEN = 6
) (
    input  logic [15:0] base,
    input  logic        base_ok,
    input  logic [15:0] addr,
    output logic        hit,
    output logic [15:0] offset
);
    localparam logic [16:0] LEN17 = 17'(NODE_LEN);

    always_comb begin
        offset = addr - base;
        hit    = base_ok && (addr >= base) && ({1'b0, offset} < LEN17);
    end

endmodule

// File: rtl/ring_parser.sv
module ring_parser
    import ring_pkg::*;
#(
    parameter logic [15:0] NODE_ID  = 16'h00A5,
    parameter int          NODE_LEN = 6,
    parameter int          IW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   in_data,
    input  logic          win_hit,
    input  logic [15:0]   win_off,
    output logic [15:0]   base_q_o,
    output logic          base_ok_o,
    output logic [15:0]   addr_o,
    output logic          out_valid,
    output logic [15:0]   out_data,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [15:0]   wr_data,
    output logic [IW-1:0] rd_idx,
    input  logic [15:0]   rd_data
);
    localparam logic [15:0] LEN16 = 16'(NODE_LEN);

    ring_state_t q, d;
    logic [15:0] off_m2;

    always_comb begin
        d           = q;
        d.out_valid = in_valid;
        d.wr_en     = 1'b0;
        off_m2      = win_off - 16'd2;
        if (in_valid) begin
            d.out_data  = in_data;
            d.last_zero = (in_data == FRAME_ZERO);
            if (q.last_zero && in_data == FRAME_MARK) begin
                d.st = ST_CMD;
            end else begin
                case (q.st)
                    ST_SEEK: d.st = ST_SEEK;
                    ST_CMD: begin
                        if (in_data == CMD_ASSIGN) begin
                            d.assign_op = 1'b1;
                            d.st        = ST_ADDR;
                        end else if (in_data[15:10] == 6'd0 && in_data[8:0] != 9'd0) begin
                            d.assign_op = 1'b0;
                            d.write_op  = in_data[9];
                            d.remain    = in_data[8:0];
                            d.st        = ST_ADDR;
                        end else begin
                            d.st = ST_SEEK;
                        end
                    end
                    ST_ADDR: begin
                        if (q.assign_op) begin
                            d.base     = in_data;
                            d.base_ok  = 1'b1;
                            d.out_data = in_data + LEN16;
                            d.st       = ST_SEEK;
                        end else begin
                            d.addr = in_data;
                            d.st   = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (win_hit) begin
                            if (q.write_op) begin
                                if (win_off >= 16'd2) begin
                                    d.wr_en   = 1'b1;
                                    d.wr_off  = off_m2;
                                    d.wr_data = in_data;
                                end
                            end else if (win_off == 16'd0) begin
                                d.out_data = NODE_ID;
                            end else if (win_off == 16'd1) begin
                                d.out_data = LEN16;
                            end else begin
                                d.out_data = rd_data;
                            end
                        end
                        d.addr   = q.addr + 16'd1;
                        d.remain = q.remain - 9'd1;
                        if (q.remain == 9'd1) d.st = ST_SEEK;
                    end
                    default: d.st = ST_SEEK;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign base_q_o  = q.base;
    assign base_ok_o = q.base_ok;
    assign addr_o    = q.addr;
    assign out_valid = q.out_valid;
    assign out_data  = q.out_data;
    assign wr_en     = q.wr_en;
    assign wr_idx    = q.wr_off[IW-1:0];
    assign wr_data   = q.wr_data;
    assign rd_idx    = off_m2[IW-1:0];

    // R5: the assigned base is kept and the next free address is forwarded
    p_assign_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q.st == ST_ADDR && q.assign_op && !(q.last_zero && in_data == FRAME_MARK))
        |=> (out_data == $past(in_data) + LEN16) && (base_q_o == $past(in_data)) && base_ok_o);

    // R6: words outside a data phase or outside the window are untouched
    p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (q.st == ST_SEEK || q.st == ST_CMD ||
                      (q.st == ST_ADDR && !q.assign_op) ||
                      (q.st == ST_DATA && !win_hit)))
        |=> (out_data == $past(in_data)) && !wr_en);

    // R4: a zero-length read or write command drops back to searching
    p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q.st == ST_CMD && in_data[15:10] == 6'd0 && in_data[8:0] == 9'd0)
        |=> q.st == ST_SEEK);

    // R9: no register write happens before a base is assigned
    p_no_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ok_o |=> !wr_en);

endmodule

// File: rtl/ring_node.sv
module ring_node #(
    parameter logic [15:0] NODE_ID  = 16'h00A5,
    parameter int          NODE_LEN = 6,
    localparam int         NREG     = NODE_LEN - 2,
    localparam int         IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   in_data,
    output logic          out_valid,
    output logic [15:0]   out_data,
    output logic          reg_wr_en,
    output logic [IW-1:0] reg_wr_idx,
    output logic [15:0]   reg_wr_data,
    output logic [IW-1:0] reg_rd_idx,
    input  logic [15:0]   reg_rd_data
);
    logic [15:0] base_w;
    logic        base_ok_w;
    logic [15:0] addr_w;
    logic        hit_w;
    logic [15:0] off_w;

    ring_window #(
        .NODE_LEN (NODE_LEN)
    ) u_window (
        .base    (base_w),
        .base_ok (base_ok_w),
        .addr    (addr_w),
        .hit     (hit_w),
        .offset  (off_w)
    );

    ring_parser #(
        .NODE_ID  (NODE_ID),
        .NODE_LEN (NODE_LEN),
        .IW       (IW)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .win_hit   (hit_w),
        .win_off   (off_w),
        .base_q_o  (base_w),
        .base_ok_o (base_ok_w),
        .addr_o    (addr_w),
        .out_valid (out_valid),
        .out_data  (out_data),
        .wr_en     (reg_wr_en),
        .wr_idx    (reg_wr_idx),
        .wr_data   (reg_wr_data),
        .rd_idx    (reg_rd_idx),
        .rd_data   (reg_rd_data)
    );

    // R1: the valid flag follows the input with exactly one clock of delay
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !reg_wr_en);

    // R8: a write strobe always carries the word it forwards
    p_wr_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_data == out_data) && out_valid);

endmodule

// File: tb/ring_node_bench.sv
module ring_node_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_idx;
    logic [15:0] reg_wr_data;
    logic [1:0]  reg_rd_idx;
    logic [15:0] reg_rd_data;
    logic [15:0] regs [4];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_node #(.NODE_ID(16'h00A5), .NODE_LEN(6)) u_ring_node (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data)
    );

    assign reg_rd_data = regs[reg_rd_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) regs[i] <= 16'h1000 + 16'(i);
        end else if (reg_wr_en) begin
            regs[reg_wr_idx] <= reg_wr_data;
        end
    end

    // {din, expected dout, expected write, expected index, requirement}
    localparam logic [38:0] VEC [NV] = '{
        // R9: read before any base assignment passes untouched
        {16'h0000,16'h0000,1'b0,2'd0,4'd9}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd9},
        {16'h0002,16'h0002,1'b0,2'd0,4'd9}, {16'h0010,16'h0010,1'b0,2'd0,4'd9},
        {16'h0000,16'h0000,1'b0,2'd0,4'd9}, {16'h0000,16'h0000,1'b0,2'd0,4'd9},
        // R5: address assignment with 0x0010, forwards 0x0016
        {16'h0000,16'h0000,1'b0,2'd0,4'd5}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd5},
        {16'hFE00,16'hFE00,1'b0,2'd0,4'd5}, {16'h0010,16'h0016,1'b0,2'd0,4'd5},
        // R7: read the whole window
        {16'h0000,16'h0000,1'b0,2'd0,4'd7}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd7},
        {16'h0006,16'h0006,1'b0,2'd0,4'd7}, {16'h0010,16'h0010,1'b0,2'd0,4'd7},
        {16'h0000,16'h00A5,1'b0,2'd0,4'd7}, {16'h0000,16'h0006,1'b0,2'd0,4'd7},
        {16'h0000,16'h1000,1'b0,2'd0,4'd7}, {16'h0000,16'h1001,1'b0,2'd0,4'd7},
        {16'h0000,16'h1002,1'b0,2'd0,4'd7}, {16'h0000,16'h1003,1'b0,2'd0,4'd7},
        // R8 / R10: write of three words crossing the upper edge
        {16'h0000,16'h0000,1'b0,2'd0,4'd8}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd8},
        {16'h0203,16'h0203,1'b0,2'd0,4'd8}, {16'h0014,16'h0014,1'b0,2'd0,4'd8},
        {16'hAAAA,16'hAAAA,1'b1,2'd2,4'd8}, {16'hBBBB,16'hBBBB,1'b1,2'd3,4'd8},
        {16'hCCCC,16'hCCCC,1'b0,2'd0,4'd10},
        // R10 / R6: read crossing the upper edge
        {16'h0000,16'h0000,1'b0,2'd0,4'd10}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd10},
        {16'h0002,16'h0002,1'b0,2'd0,4'd10}, {16'h0015,16'h0015,1'b0,2'd0,4'd10},
        {16'h0000,16'hBBBB,1'b0,2'd0,4'd10}, {16'h0000,16'h0000,1'b0,2'd0,4'd6},
        // R11: word after the message end
        {16'h1234,16'h1234,1'b0,2'd0,4'd11},
        // R4: zero-length read is ignored
        {16'h0000,16'h0000,1'b0,2'd0,4'd4}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd4},
        {16'h0000,16'h0000,1'b0,2'd0,4'd4}, {16'h0012,16'h0012,1'b0,2'd0,4'd4},
        {16'h0000,16'h0000,1'b0,2'd0,4'd4},
        // R3: unknown command abandons the frame
        {16'hEB90,16'hEB90,1'b0,2'd0,4'd3}, {16'hF000,16'hF000,1'b0,2'd0,4'd3},
        {16'h0012,16'h0012,1'b0,2'd0,4'd3}, {16'h0000,16'h0000,1'b0,2'd0,4'd3},
        // R2: a new frame marker in mid message restarts parsing
        {16'hEB90,16'hEB90,1'b0,2'd0,4'd2}, {16'h0004,16'h0004,1'b0,2'd0,4'd2},
        {16'h0010,16'h0010,1'b0,2'd0,4'd2}, {16'h0000,16'h00A5,1'b0,2'd0,4'd2},
        {16'h0000,16'h0006,1'b0,2'd0,4'd2}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd2},
        {16'h0001,16'h0001,1'b0,2'd0,4'd2}, {16'h0013,16'h0013,1'b0,2'd0,4'd2},
        {16'h0000,16'h1001,1'b0,2'd0,4'd2},
        // R8: writes to offsets 0 and 1 are ignored
        {16'h0000,16'h0000,1'b0,2'd0,4'd8}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd8},
        {16'h0202,16'h0202,1'b0,2'd0,4'd8}, {16'h0010,16'h0010,1'b0,2'd0,4'd8},
        {16'h5555,16'h5555,1'b0,2'd0,4'd8}, {16'h6666,16'h6666,1'b0,2'd0,4'd8},
        // R7: identity and length unchanged after that write
        {16'h0000,16'h0000,1'b0,2'd0,4'd7}, {16'hEB90,16'hEB90,1'b0,2'd0,4'd7},
        {16'h0002,16'h0002,1'b0,2'd0,4'd7}, {16'h0010,16'h0010,1'b0,2'd0,4'd7},
        {16'h0000,16'h00A5,1'b0,2'd0,4'd7}, {16'h0000,16'h0006,1'b0,2'd0,4'd7}
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] d, input logic [15:0] e, input int rq);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, rq, "out_valid", 16'(out_valid), 16'h1);
        check(out_data == e, rq, "out_data", out_data, e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0, 1, "reset out_valid", 16'(out_valid), 16'h0);
        check(reg_wr_en == 1'b0, 1, "reset reg_wr_en", 16'(reg_wr_en), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = VEC[v][38:23];
            @(posedge clk);
            #1;
            check(out_valid == 1'b1, int'(VEC[v][3:0]), "out_valid", 16'(out_valid), 16'h1);
            check(out_data == VEC[v][22:7], int'(VEC[v][3:0]), "out_data",
                  out_data, VEC[v][22:7]);
            check(reg_wr_en == VEC[v][6], int'(VEC[v][3:0]), "reg_wr_en",
                  16'(reg_wr_en), 16'(VEC[v][6]));
            if (VEC[v][6]) begin
                check(reg_wr_idx == VEC[v][5:4], int'(VEC[v][3:0]), "reg_wr_idx",
                      16'(reg_wr_idx), 16'(VEC[v][5:4]));
                check(reg_wr_data == VEC[v][38:23], int'(VEC[v][3:0]), "reg_wr_data",
                      reg_wr_data, VEC[v][38:23]);
            end
        end

        // R1: an idle cycle in mid message gives a low out_valid, parsing holds
        send_word(16'h0000, 16'h0000, 1);
        send_word(16'hEB90, 16'hEB90, 1);
        send_word(16'h0001, 16'h0001, 1);
        send_word(16'h0012, 16'h0012, 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'h7777;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, 1, "gap out_valid", 16'(out_valid), 16'h0);
        check(reg_wr_en == 1'b0, 1, "gap reg_wr_en", 16'(reg_wr_en), 16'h0);
        // R7: the held read resumes and returns register 0
        send_word(16'h0000, 16'h1000, 7);
        // R11: back to searching afterwards
        send_word(16'h0000, 16'h0000, 11);

        @(negedge clk);
        in_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual %0d expected %0d", 20000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule